// File: doc/BRIEF.md
# Latched Bidirectional Bus Transceiver Bank

This block gives a set of independent one-bit channels. Each channel links a push-pull A side to a wired-OR B side through a storage element. Every pin is split into separate data-in, data-out and drive-enable signals, so the block can sit inside a synchronous chip and leave the physical pads to the surrounding logic. The A side is driven only while its active-high enable is set. While the A side is disabled, `a_out` reads 0 in place of high impedance. The B side is open-drain. It can only pull the shared line low, and it does so under an active-low enable.

Each channel has a storage stage that opens while its active-low open signal is low. The A-side enable chooses where the stage loads from. With the A side disabled it loads from the A input, which carries traffic from A to B. With the A side enabled it loads from the B input, which carries traffic from B to A. While the stage is closed, both enabled sides show the held value.

The stage is a register that loads on the clock edge. Output changes therefore appear one clock after the input is sampled. If a channel drives both sides while its stage is open, the signal path loops back on itself, and a per-channel flag reports this.

The surrounding logic resolves the B line as a wired-AND of the external bus and the block's pull-low. A line that nobody drives is resolved as logic 0.

Top module: `latched_xcvr_bank`

## Requirements
- R1: Synchronous reset with `rst_n` low sets every channel's stored value to 1. After reset, a channel with both sides enabled shows `a_out`=1 and `b_pull_low`=0.
- R2: On a clock edge where `lat_open_n[i]`=0 and `a_oe[i]`=0, channel i stores `a_in[i]`.
- R3: On a clock edge where `lat_open_n[i]`=0 and `a_oe[i]`=1, channel i stores `b_in[i]`.
- R4: On a clock edge where `lat_open_n[i]`=1, channel i keeps its stored value whatever `a_in`, `b_in` and the enables do.
- R5: When `a_oe[i]`=0, `a_out[i]` is 0 (A side released). When `a_oe[i]`=1, `a_out[i]` equals the stored value.
- R6: `b_pull_low[i]` is 1 exactly when `b_oe_n[i]`=0 and the stored value is 0. A stored 1 releases the line.
- R7: `loop_flag[i]` is 1 exactly when `a_oe[i]`=1, `b_oe_n[i]`=0 and `lat_open_n[i]`=0, evaluated on the current inputs.
- R8: Channels are independent. Each channel's stored value and outputs depend only on that channel's inputs.
- R9: With both sides of a channel enabled, A and B show the same state: `a_out[i]`=1 exactly when `b_pull_low[i]`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lat_open_n | input | NUM_CH | Storage stage open per channel, active low |
| a_oe | input | NUM_CH | A-side drive enable, active high; also selects B as the load source |
| b_oe_n | input | NUM_CH | B-side pull-low enable, active low |
| a_in | input | NUM_CH | Level sensed on the A side |
| b_in | input | NUM_CH | Resolved level of the B line |
| a_out | output | NUM_CH | A-side data, 0 while A is disabled |
| b_pull_low | output | NUM_CH | 1 pulls the B line low |
| loop_flag | output | NUM_CH | Feedback condition detected |

## Verification
Alternating one-hot and inverted patterns drive the A-to-B path, the B-to-A path and the closed stage. These patterns separate a channel that loads from the wrong side, and a stage that leaks while closed, from correct behaviour. Mixed vectors put each channel in a different mode in the same cycle, which exposes any crossing between channels. The feedback case closes the wired-AND loop through the block's own pull-low and must keep the stored value unchanged while raising the flag. Releasing the external bus shows that an undriven line loads as 0 on the B-to-A path.

// File: rtl/xcvr_pkg.sv
// Shared types for the latched transceiver bank.
// Assumes single-bit channels; the source select names the side the stage loads from.
package xcvr_pkg;
    typedef enum logic {
        SRC_FROM_A = 1'b0,
        SRC_FROM_B = 1'b1
    } load_src_e;

    // Map the A-side enable onto the load source.
    function automatic load_src_e src_of(input logic a_enable);
        return a_enable ? SRC_FROM_B : SRC_FROM_A;
    endfunction
endpackage

// File: rtl/xcvr_src_mux.sv
// Selects the data the storage stage loads for one channel.
// Assumes the A-side enable alone decides the direction of travel.
module xcvr_src_mux
    import xcvr_pkg::*;
(
    input  logic a_oe,
    input  logic a_in,
    input  logic b_in,
    output logic d_sel
);
    load_src_e src;

    // Choose the load source from the A-side enable.
    always_comb begin
        src   = src_of(a_oe);
        d_sel = (src == SRC_FROM_B) ? b_in : a_in;
    end
endmodule

// File: rtl/xcvr_latch_cell.sv
// Storage stage for one channel: a register that loads while open (open_n low).
// Assumes a synchronous active-low reset to RESET_LEVEL.
module xcvr_latch_cell #(
    parameter logic RESET_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic open_n,
    input  logic d,
    output logic q
);
    // Load on an open edge, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= RESET_LEVEL;
        else if (!open_n)
            q <= d;
    end
endmodule

// File: rtl/xcvr_port_drive.sv
// Output stage for one channel: gated push-pull A data and open-drain B pull-low.
// Assumes a released A side reads 0 and a stored 1 releases the B line.
module xcvr_port_drive (
    input  logic q,
    input  logic a_oe,
    input  logic b_oe_n,
    output logic a_out,
    output logic b_pull_low
);
    // Gate A data and form the B pull-low from the stored value.
    always_comb begin
        a_out      = a_oe & q;
        b_pull_low = ~b_oe_n & ~q;
    end
endmodule

// File: rtl/xcvr_loop_detect.sv
// Flags channels where both sides drive while the stage is open.
// Assumes the flag is a function of the current inputs only.
module xcvr_loop_detect #(
    parameter int NUM_CH = 3
) (
    input  logic [NUM_CH-1:0] lat_open_n,
    input  logic [NUM_CH-1:0] a_oe,
    input  logic [NUM_CH-1:0] b_oe_n,
    output logic [NUM_CH-1:0] loop_flag
);
    // Detect the feedback path per channel.
    always_comb begin
        loop_flag = a_oe & ~b_oe_n & ~lat_open_n;
    end
endmodule

// File: rtl/latched_xcvr_bank.sv
// Bank of independent latched bidirectional transceiver channels.
// Each channel: source mux -> storage stage -> port drive. Loop detection covers all channels.
// Assumes pads and bus resolution live outside; the B input is already resolved.
module latched_xcvr_bank #(
    parameter int   NUM_CH      = 3,
    parameter logic RESET_LEVEL = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] lat_open_n,
    input  logic [NUM_CH-1:0] a_oe,
    input  logic [NUM_CH-1:0] b_oe_n,
    input  logic [NUM_CH-1:0] a_in,
    input  logic [NUM_CH-1:0] b_in,
    output logic [NUM_CH-1:0] a_out,
    output logic [NUM_CH-1:0] b_pull_low,
    output logic [NUM_CH-1:0] loop_flag
);
    logic [NUM_CH-1:0] d_sel;
    logic [NUM_CH-1:0] latch_q;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        xcvr_src_mux u_mux (
            .a_oe  (a_oe[i]),
            .a_in  (a_in[i]),
            .b_in  (b_in[i]),
            .d_sel (d_sel[i])
        );

        xcvr_latch_cell #(.RESET_LEVEL(RESET_LEVEL)) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .open_n (lat_open_n[i]),
            .d      (d_sel[i]),
            .q      (latch_q[i])
        );

        xcvr_port_drive u_drv (
            .q          (latch_q[i]),
            .a_oe       (a_oe[i]),
            .b_oe_n     (b_oe_n[i]),
            .a_out      (a_out[i]),
            .b_pull_low (b_pull_low[i])
        );
    end

    xcvr_loop_detect #(.NUM_CH(NUM_CH)) u_loop (
        .lat_open_n (lat_open_n),
        .a_oe       (a_oe),
        .b_oe_n     (b_oe_n),
        .loop_flag  (loop_flag)
    );
endmodule

// File: rtl/xcvr_bank_chk.sv
// Property checker for latched_xcvr_bank, attached by bind below.
// Assumes synchronous active-low reset; all properties are disabled while it is low.
module xcvr_bank_chk #(
    parameter int NUM_CH = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] lat_open_n,
    input logic [NUM_CH-1:0] a_oe,
    input logic [NUM_CH-1:0] b_oe_n,
    input logic [NUM_CH-1:0] a_in,
    input logic [NUM_CH-1:0] b_in,
    input logic [NUM_CH-1:0] a_out,
    input logic [NUM_CH-1:0] b_pull_low,
    input logic [NUM_CH-1:0] loop_flag,
    input logic [NUM_CH-1:0] latch_q
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        a_r2_load_from_a: assert property (@(posedge clk) disable iff (!rst_n)
            (!lat_open_n[i] && !a_oe[i]) |=> (latch_q[i] == $past(a_in[i])));

        a_r3_load_from_b: assert property (@(posedge clk) disable iff (!rst_n)
            (!lat_open_n[i] && a_oe[i]) |=> (latch_q[i] == $past(b_in[i])));

        a_r4_closed_hold: assert property (@(posedge clk) disable iff (!rst_n)
            lat_open_n[i] |=> $stable(latch_q[i]));

        a_r5_a_released: assert property (@(posedge clk) disable iff (!rst_n)
            !a_oe[i] |-> !a_out[i]);

        a_r6_pull_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
            b_pull_low[i] |-> !b_oe_n[i]);

        a_r7_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
            loop_flag[i] |-> (a_oe[i] && !b_oe_n[i] && !lat_open_n[i]));

        a_r9_sides_agree: assert property (@(posedge clk) disable iff (!rst_n)
            (a_oe[i] && !b_oe_n[i]) |-> (a_out[i] != b_pull_low[i]));
    end
endmodule

bind latched_xcvr_bank xcvr_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lat_open_n (lat_open_n),
    .a_oe       (a_oe),
    .b_oe_n     (b_oe_n),
    .a_in       (a_in),
    .b_in       (b_in),
    .a_out      (a_out),
    .b_pull_low (b_pull_low),
    .loop_flag  (loop_flag),
    .latch_q    (latch_q)
);

// File: tb/sim_latched_xcvr_bank.sv
// Scoreboard bench: the driver task predicts results into a queue, the monitor compares them.
module sim_latched_xcvr_bank;
    localparam int N = 3;

    typedef struct {
        logic [N-1:0] exp_a;
        logic [N-1:0] exp_b;
        logic [N-1:0] exp_l;
        string        tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] lat_open_n = '1;
    logic [N-1:0] a_oe = '1;
    logic [N-1:0] b_oe_n = '0;
    logic [N-1:0] a_in = '0;
    logic [N-1:0] ext_level = '1;
    logic [N-1:0] b_in;
    logic [N-1:0] a_out;
    logic [N-1:0] b_pull_low;
    logic [N-1:0] loop_flag;

    item_t        sb[$];
    logic [N-1:0] mq = '1;
    int           n_tests = 0;
    int           n_fail = 0;
    bit           done = 1'b0;

    always #5 clk = ~clk;

    // Wired-AND bus: an external 0 (or an undriven line) and our own pull-low both force 0.
    assign b_in = ext_level & ~b_pull_low;

    latched_xcvr_bank #(.NUM_CH(N)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .lat_open_n (lat_open_n),
        .a_oe       (a_oe),
        .b_oe_n     (b_oe_n),
        .a_in       (a_in),
        .b_in       (b_in),
        .a_out      (a_out),
        .b_pull_low (b_pull_low),
        .loop_flag  (loop_flag)
    );

    task automatic check(input string tag, input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    // Drive one cycle of inputs and push the predicted outputs after the edge.
    task automatic step(input logic [N-1:0] le, input logic [N-1:0] aoe, input logic [N-1:0] boen,
                        input logic [N-1:0] ain, input logic [N-1:0] ext, input string tag);
        item_t        it;
        logic [N-1:0] pull_now;
        logic [N-1:0] bus_now;
        @(negedge clk);
        lat_open_n = le;
        a_oe       = aoe;
        b_oe_n     = boen;
        a_in       = ain;
        ext_level  = ext;
        pull_now = ~boen & ~mq;
        bus_now  = ext & ~pull_now;
        for (int i = 0; i < N; i++)
            if (!le[i]) mq[i] = aoe[i] ? bus_now[i] : ain[i];
        it.exp_a = aoe & mq;
        it.exp_b = ~boen & ~mq;
        it.exp_l = aoe & ~boen & ~le;
        it.tag   = tag;
        sb.push_back(it);
        @(posedge clk);
    endtask

    // Monitor: compare outputs shortly after each edge.
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check(it.tag, "a_out", a_out, it.exp_a);
            check(it.tag, "b_pull_low", b_pull_low, it.exp_b);
            check(it.tag, "loop_flag", loop_flag, it.exp_l);
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: stored value 1 after reset, both sides enabled, stage closed
        step(3'b111, 3'b111, 3'b000, 3'b000, 3'b111, "R1");
        // R2: A to B, one pattern and its inverse; R5: A released reads 0
        step(3'b000, 3'b000, 3'b000, 3'b101, 3'b111, "R2_R5");
        step(3'b000, 3'b000, 3'b000, 3'b010, 3'b111, "R2");
        // R4: closed stage ignores A changes
        step(3'b111, 3'b000, 3'b000, 3'b101, 3'b111, "R4");
        // R6: B disabled releases the line whatever is stored
        step(3'b111, 3'b000, 3'b111, 3'b000, 3'b111, "R6");
        // R3: B to A with B released, external pattern 110
        step(3'b000, 3'b111, 3'b111, 3'b000, 3'b110, "R3");
        step(3'b000, 3'b111, 3'b111, 3'b111, 3'b011, "R3");
        // R4: closed stage ignores B changes
        step(3'b111, 3'b111, 3'b111, 3'b000, 3'b100, "R4");
        // R9: both sides enabled, closed: same state on A and B
        step(3'b111, 3'b111, 3'b000, 3'b000, 3'b111, "R9");
        // R7: feedback condition with both sides enabled and stage open; value keeps itself
        step(3'b000, 3'b111, 3'b000, 3'b000, 3'b111, "R7");
        step(3'b010, 3'b101, 3'b000, 3'b000, 3'b111, "R7");
        // R8: ch0 A->B, ch1 B->A, ch2 held
        step(3'b100, 3'b010, 3'b101, 3'b001, 3'b010, "R8");
        step(3'b100, 3'b010, 3'b101, 3'b000, 3'b000, "R8");
        // R3: undriven B line loads as 0
        step(3'b000, 3'b111, 3'b111, 3'b111, 3'b000, "R3");
        // R2: load all ones from A, then R1 reset again
        step(3'b000, 3'b000, 3'b000, 3'b111, 3'b111, "R2");
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        mq = '1;
        step(3'b111, 3'b111, 3'b000, 3'b000, 3'b111, "R1");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule